// File: doc/BRIEF.md
# Second-Order IIR Filter Section (Direct Form I, Saturating)

This block is one second-order recursive filter section for a single audio channel. Each accepted input sample produces one output sample. The output is formed from the new sample, the two previous input samples and the two previous output samples, each weighted by a programmable coefficient. The two input-history registers and the two output-history registers are kept separately, so the section has Direct Form I structure.

The coefficients arrive as parallel inputs that are already latched. Each one is a 24-bit signed fixed-point value with two integer bits and 21 fraction bits. The two feedback weights are supplied already negated, so the datapath only adds its five products. The sum is kept at full precision, scaled back to sample units, and clamped to the 24-bit sample range instead of wrapping. The clamped value is the one stored as output history.

Samples enter and leave through valid/ready streams. The output side holds one result. `in_ready` is high whenever that result slot is empty or is being drained in the same cycle, and `clr` is low. While `out_valid` is high and `out_ready` is low, the result and all history stay frozen, and no input is taken. A synchronous clear empties the history.

Top module: `dfi_biquad`

## Requirements
- R1: After reset, `out_valid` is 0, `in_ready` is 1 and all four history registers hold zero.
- R2: `in_ready` equals (`out_valid` == 0 or `out_ready` == 1) and `clr` == 0. A sample is accepted only on a rising clock edge where `in_valid` and `in_ready` are both 1.
- R3: For an accepted sample x, the sum is S = b0·x + b1·x1 + b2·x2 + a1·y1 + a2·y2. Here x1 and x2 are the previous two accepted inputs, and y1 and y2 are the previous two outputs. a1 and a2 are added as given, with no sign change.
- R4: Samples are 24-bit two's complement. Coefficients are 24-bit two's complement with 21 fraction bits (value = code/2^21, range -4 to just under +4). The result before clamping is floor(S / 2^21), formed by an arithmetic right shift of the full-precision sum.
- R5: If that result is above 8388607, the output is 8388607 (0x7FFFFF). If it is below -8388608, the output is -8388608 (0x800000). Otherwise it is passed through unchanged.
- R6: The clamped output value is the one that becomes y1 for the next sample. y1 moves to y2.
- R7: The result appears on `out_sample` with `out_valid` = 1 in the cycle after the accepting edge. `out_valid` drops after a handshake edge (`out_valid` and `out_ready` both 1) that accepts no new sample.
- R8: While `out_valid` = 1 and `out_ready` = 0, `out_sample` holds its value and `out_valid` stays 1.
- R9: When `clr` is 1 at a clock edge, all four history registers become zero, and no sample is accepted in that cycle.
- R10: The history registers change only on an accepting edge or a clearing edge. Sample values presented while `in_ready` is 0 have no effect on later outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clr | input | 1 | Synchronous history clear |
| coef_b0 | input | 24 | Weight of the current input |
| coef_b1 | input | 24 | Weight of the input one sample back |
| coef_b2 | input | 24 | Weight of the input two samples back |
| coef_a1 | input | 24 | Pre-negated weight of the output one sample back |
| coef_a2 | input | 24 | Pre-negated weight of the output two samples back |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Section can take a sample |
| in_sample | input | 24 | Signed input sample |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_sample | output | 24 | Signed, clamped result |

## Verification
The bench drives the sum past both ends of the sample range.
- A section that wraps instead of clamping would return values of the wrong sign.
- A section that fed back an unclamped or wrapped value would give a wrong next output. With a half-weight feedback tap after a clamp, the correct next output is exactly 4194303.

Negative sums that are not multiples of 2^21 separate flooring from truncation toward zero. Delay-only coefficient settings show whether x1 and x2 shift in the right order.

Inputs that change while the output is stalled show whether the section took a sample it had not accepted. A clear followed by history-only taps shows whether all four registers were emptied.

// File: rtl/biquad_pkg.sv
package biquad_pkg;
  // Tap positions shared by the operand and coefficient vectors
  typedef enum int {
    TAP_X0 = 0,
    TAP_X1 = 1,
    TAP_X2 = 2,
    TAP_Y1 = 3,
    TAP_Y2 = 4
  } tap_e;

  localparam int NUM_TAPS  = 5;
  localparam int HIST_LEN  = 2;
endpackage

// File: rtl/biquad_mac.sv
// Five parallel signed products summed at full precision.
module biquad_mac
  import biquad_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int COEF_W = 24,
  parameter int ACC_W  = DATA_W + COEF_W + 4
) (
  input  logic [NUM_TAPS-1:0][DATA_W-1:0] opnd_i,
  input  logic [NUM_TAPS-1:0][COEF_W-1:0] coef_i,
  output logic signed [ACC_W-1:0]         acc_o
);
  localparam int PROD_W = DATA_W + COEF_W;

  logic signed [PROD_W-1:0] prod [NUM_TAPS];

  for (genvar t = 0; t < NUM_TAPS; t++) begin : g_tap
    always_comb begin
      prod[t] = $signed(opnd_i[t]) * $signed(coef_i[t]);
    end
  end

  always_comb begin
    acc_o = '0;
    for (int t = 0; t < NUM_TAPS; t++) begin
      acc_o = acc_o + ACC_W'(prod[t]);
    end
  end
endmodule

// File: rtl/biquad_sat.sv
// Scale the accumulator to sample units (floor) and clamp to the sample range.
module biquad_sat #(
  parameter int ACC_W  = 52,
  parameter int FRAC_W = 21,
  parameter int DATA_W = 24
) (
  input  logic signed [ACC_W-1:0]  acc_i,
  output logic signed [DATA_W-1:0] y_o,
  output logic                     clip_hi_o,
  output logic                     clip_lo_o
);
  localparam logic signed [ACC_W-1:0] MAXV =
    {{(ACC_W-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] MINV =
    {{(ACC_W-DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}};

  logic signed [ACC_W-1:0] scaled;

  always_comb begin
    scaled    = acc_i >>> FRAC_W;
    clip_hi_o = scaled > MAXV;
    clip_lo_o = scaled < MINV;
    if (clip_hi_o)      y_o = {1'b0, {(DATA_W-1){1'b1}}};
    else if (clip_lo_o) y_o = {1'b1, {(DATA_W-1){1'b0}}};
    else                y_o = scaled[DATA_W-1:0];
  end
endmodule

// File: rtl/biquad_hist.sv
// Tapped delay line of DEPTH words; shifts on en, zeroes on clr.
module biquad_hist #(
  parameter int W     = 24,
  parameter int DEPTH = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clr,
  input  logic                      en,
  input  logic [W-1:0]              din,
  output logic [DEPTH-1:0][W-1:0]   taps_o
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   taps_o[i] <= '0;
      else if (clr) taps_o[i] <= '0;
      else if (en) begin
        if (i == 0) taps_o[i] <= din;
        else        taps_o[i] <= taps_o[(i == 0) ? 0 : i-1];
      end
    end
  end

  // R9: clear empties every stage
  a_r9_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (taps_o == '0));
  // R10: history is untouched without a shift or clear
  a_r10_hist_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !clr) |=> $stable(taps_o));
endmodule

// File: rtl/dfi_biquad.sv
module dfi_biquad
  import biquad_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int COEF_W = 24,
  parameter int FRAC_W = 21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic [COEF_W-1:0] coef_b0,
  input  logic [COEF_W-1:0] coef_b1,
  input  logic [COEF_W-1:0] coef_b2,
  input  logic [COEF_W-1:0] coef_a1,
  input  logic [COEF_W-1:0] coef_a2,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_sample,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_sample
);
  localparam int ACC_W = DATA_W + COEF_W + 4;
  localparam logic [DATA_W-1:0] POS_LIM = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] NEG_LIM = {1'b1, {(DATA_W-1){1'b0}}};

  logic                             in_fire;
  logic [HIST_LEN-1:0][DATA_W-1:0]  x_hist;
  logic [HIST_LEN-1:0][DATA_W-1:0]  y_hist;
  logic [NUM_TAPS-1:0][DATA_W-1:0]  opnd;
  logic [NUM_TAPS-1:0][COEF_W-1:0]  coef;
  logic signed [ACC_W-1:0]          acc;
  logic signed [DATA_W-1:0]         y_new;
  logic                             clip_hi, clip_lo;

  assign in_ready = (!out_valid || out_ready) && !clr;
  assign in_fire  = in_valid && in_ready;

  always_comb begin
    opnd[TAP_X0] = in_sample;
    opnd[TAP_X1] = x_hist[0];
    opnd[TAP_X2] = x_hist[1];
    opnd[TAP_Y1] = y_hist[0];
    opnd[TAP_Y2] = y_hist[1];
    coef[TAP_X0] = coef_b0;
    coef[TAP_X1] = coef_b1;
    coef[TAP_X2] = coef_b2;
    coef[TAP_Y1] = coef_a1;
    coef[TAP_Y2] = coef_a2;
  end

  biquad_mac #(.DATA_W(DATA_W), .COEF_W(COEF_W), .ACC_W(ACC_W)) u_mac (
    .opnd_i (opnd),
    .coef_i (coef),
    .acc_o  (acc)
  );

  biquad_sat #(.ACC_W(ACC_W), .FRAC_W(FRAC_W), .DATA_W(DATA_W)) u_sat (
    .acc_i     (acc),
    .y_o       (y_new),
    .clip_hi_o (clip_hi),
    .clip_lo_o (clip_lo)
  );

  biquad_hist #(.W(DATA_W), .DEPTH(HIST_LEN)) u_xhist (
    .clk (clk), .rst_n (rst_n), .clr (clr), .en (in_fire),
    .din (in_sample), .taps_o (x_hist)
  );

  biquad_hist #(.W(DATA_W), .DEPTH(HIST_LEN)) u_yhist (
    .clk (clk), .rst_n (rst_n), .clr (clr), .en (in_fire),
    .din (y_new), .taps_o (y_hist)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_sample <= '0;
    end else if (in_fire) begin
      out_valid  <= 1'b1;
      out_sample <= y_new;
    end else if (out_ready) begin
      out_valid  <= 1'b0;
    end
  end

  // R7: a result follows every accepted sample one cycle later
  a_r7_latency: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire |=> out_valid);
  // R8: a stalled result is held
  a_r8_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_sample)));
  // R6: the emitted value is what enters the output history
  a_r6_feedback: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire |=> (y_hist[0] == out_sample));
  // R5: clamping at both ends of the range
  a_r5_clip_hi: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fire && clip_hi) |=> (out_sample == POS_LIM));
  a_r5_clip_lo: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fire && clip_lo) |=> (out_sample == NEG_LIM));
endmodule

// File: tb/dfi_biquad_tb.sv
module dfi_biquad_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr = 1'b0;
  logic [23:0] cb0 = '0, cb1 = '0, cb2 = '0, ca1 = '0, ca2 = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [23:0] in_sample = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [23:0] out_sample;

  int n_tests = 0;
  int n_fail  = 0;

  // bench model state
  longint mx1 = 0, mx2 = 0, my1 = 0, my2 = 0;
  int unsigned seed = 32'h1BADB002;

  localparam longint ONE = 64'sd2097152; // 1.0 in S2.21

  always #5 clk = ~clk;

  dfi_biquad u_dut (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .coef_b0(cb0), .coef_b1(cb1), .coef_b2(cb2), .coef_a1(ca1), .coef_a2(ca2),
    .in_valid(in_valid), .in_ready(in_ready), .in_sample(in_sample),
    .out_valid(out_valid), .out_ready(out_ready), .out_sample(out_sample)
  );

  function automatic longint sx(logic [23:0] v);
    return longint'($signed(v));
  endfunction

  function automatic int unsigned rnd();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  // model step: returns expected clamped output, updates history
  function automatic longint model(logic [23:0] x);
    longint acc, q;
    acc = sx(cb0)*sx(x) + sx(cb1)*mx1 + sx(cb2)*mx2 + sx(ca1)*my1 + sx(ca2)*my2;
    q = acc >>> 21;
    if (q > 8388607) q = 8388607;
    if (q < -8388608) q = -8388608;
    mx2 = mx1; mx1 = sx(x);
    my2 = my1; my1 = q;
    return q;
  endfunction

  task automatic check(string req, longint act, longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_coef(longint b0, longint b1, longint b2, longint a1, longint a2);
    cb0 = b0[23:0]; cb1 = b1[23:0]; cb2 = b2[23:0]; ca1 = a1[23:0]; ca2 = a2[23:0];
  endtask

  task automatic model_clear();
    mx1 = 0; mx2 = 0; my1 = 0; my2 = 0;
  endtask

  // send one sample with out_ready high; check its result
  task automatic send(logic [23:0] x, string req);
    longint exp;
    @(negedge clk);
    in_valid = 1'b1; in_sample = x;
    exp = model(x);
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " valid"}, longint'(out_valid), 1);
    check(req, sx(out_sample), exp);
  endtask

  task automatic do_clear();
    @(negedge clk);
    clr = 1'b1;
    #1 check("R9 in_ready low during clear", longint'(in_ready), 0);
    @(negedge clk);
    clr = 1'b0;
    model_clear();
  endtask

  task automatic t_reset();
    check("R1 out_valid after reset", longint'(out_valid), 0);
    check("R1 in_ready after reset", longint'(in_ready), 1);
    // history-only taps give zero output if all history is zero
    set_coef(0, ONE, ONE, ONE, ONE);
    send(24'h000000, "R1 history zero");
  endtask

  task automatic t_passthrough();
    set_coef(ONE, 0, 0, 0, 0);
    send(24'h123456, "R3 passthrough pos");
    send(24'hF00001, "R3 passthrough neg");
    send(24'h7FFFFF, "R3 passthrough max");
  endtask

  task automatic t_delay_order();
    do_clear();
    set_coef(0, ONE, 2*ONE, 0, 0);
    send(24'd100, "R3 delay taps");
    send(24'd7, "R3 delay taps x1");
    send(24'd0, "R3 delay taps x1,x2 order");
    send(24'd0, "R3 delay taps x2");
  endtask

  task automatic t_floor();
    do_clear();
    set_coef(ONE/2, 0, 0, 0, 0);
    send(24'hFFFFFD, "R4 floor of -1.5 is -2");
    send(24'd3, "R4 floor of 1.5 is 1");
  endtask

  task automatic t_feedback();
    do_clear();
    set_coef(ONE, 0, 0, ONE + ONE/2, -(ONE*3/4)); // pre-negated feedback
    send(24'd100000, "R3 feedback impulse");
    for (int i = 0; i < 10; i++) send(24'd0, "R3 feedback ring");
  endtask

  task automatic t_random();
    do_clear();
    set_coef(ONE/3, -(ONE/5), ONE/7, ONE/2, -(ONE/4));
    for (int i = 0; i < 40; i++) send(rnd() & 24'hFFFFFF, "R4 random stream");
    do_clear();
    set_coef(longint'(3*ONE), longint'(-3*ONE), longint'(2*ONE), ONE, -(ONE/2));
    for (int i = 0; i < 40; i++) send(rnd() & 24'hFFFFFF, "R5 random with clipping");
  endtask

  task automatic t_saturate();
    do_clear();
    set_coef(longint'(8388607), 0, 0, 0, 0); // just under +4.0
    send(24'h7FFFFF, "R5 clip high");
    send(24'h800000, "R5 clip low");
    do_clear();
    set_coef(longint'(8388607), 0, 0, ONE/2, 0);
    send(24'h7FFFFF, "R5 clip high before feedback");
    set_coef(0, 0, 0, ONE/2, 0);
    send(24'h000000, "R6 clamped value fed back");
    check("R6 clamped feedback exact", my1, 4194303);
  endtask

  task automatic t_backpressure();
    longint held, exp;
    do_clear();
    set_coef(ONE, ONE/2, 0, 0, 0);
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_sample = 24'd1000;
    held = model(24'd1000);
    @(negedge clk);
    in_sample = 24'd55555;
    check("R2 in_ready low while stalled", longint'(in_ready), 0);
    check("R7 result valid", longint'(out_valid), 1);
    check("R7 result value", sx(out_sample), held);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      in_sample = 24'(777 + i * 11);
      check("R8 held valid", longint'(out_valid), 1);
      check("R8 held value", sx(out_sample), held);
    end
    in_sample = 24'd2000;
    out_ready = 1'b1;
    #1 check("R2 in_ready when drained", longint'(in_ready), 1);
    exp = model(24'd2000);
    @(negedge clk);
    in_valid = 1'b0;
    check("R10 stalled inputs ignored", sx(out_sample), exp);
    @(negedge clk);
    check("R7 out_valid drops after handshake", longint'(out_valid), 0);
  endtask

  task automatic t_clear();
    set_coef(ONE, ONE, ONE, ONE/2, ONE/2);
    send(24'd4000, "R3 before clear");
    send(24'd9000, "R3 before clear");
    @(negedge clk);
    clr = 1'b1; in_valid = 1'b1; in_sample = 24'd5;
    @(negedge clk);
    clr = 1'b0; in_valid = 1'b0;
    check("R9 no accept during clear", longint'(out_valid), 0);
    model_clear();
    set_coef(0, ONE, ONE, ONE, ONE);
    send(24'd0, "R9 history cleared");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired (R7) actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_passthrough();
    t_delay_order();
    t_floor();
    t_feedback();
    t_saturate();
    t_backpressure();
    t_clear();
    t_random();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule